// File: doc/BRIEF.md
# Dual-I/O Flash Read Responder

This block plays the target side of a serial flash dual-I/O fast read. It watches a chip select, a serial clock and two data lines (split into input, output and per-line output-enable pins), oversampling all of them with the system clock. After chip select falls, it shifts in an 8-bit command on line 0. When the command selects the dual read, it takes a 24-bit address two bits per serial clock, lets four dummy clocks pass, and then streams bytes from a small internal byte memory, two bits per serial clock. The read pointer steps by one after each byte and wraps to zero past the last entry. The stream runs until chip select rises.

A valid/ready write port preloads the memory. Back-pressure rule: `wr_ready` is high only while the responder is idle, meaning chip select is high after synchronisation. A word transfers in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the address and data on the port are ignored and must be held by the sender. The memory depth is a parameter and must be a power of two. The serial clock and chip select must each stay at one level for at least four system clocks.

Top module: `dio_read_responder`

## Requirements
- R1: After reset, with chip select high, `io_oe` is 2'b00 and `wr_ready` is 1.
- R2: The command is shifted in from `io_in[0]` on rising serial clock edges, MSB first, eight edges. Only the value 0xBB starts a read.
- R3: The address is 12 rising edges of bit pairs, most significant pair first. `io_in[1]` carries the odd-numbered bit of each pair and `io_in[0]` the even-numbered one.
- R4: The four dummy clocks are ignored whatever the lines carry. `io_oe` stays 2'b00 from chip select falling until the first falling serial clock edge after the fourth dummy rising edge.
- R5: Each output byte is driven on four falling edges, bits [7:6] first. `io_out[1]` carries bits 7, 5, 3 and 1, and `io_out[0]` carries bits 6, 4, 2 and 0. Outputs change only after a falling edge and are stable while the serial clock is high, with `io_oe` at 2'b11.
- R6: The first byte comes from the given address. Each further byte comes from the next address, and address DEPTH-1 is followed by address 0.
- R7: The stream continues for as long as chip select is low. A rise of chip select at any bit position releases `io_oe` to 2'b00 within four clocks, and the next transaction decodes from a clean start.
- R8: A command other than 0xBB makes the block ignore all traffic until chip select rises. `io_oe` stays 2'b00 throughout.
- R9: A write occurs when `wr_valid` and `wr_ready` are both high. `wr_ready` is 0 while chip select is low, and a write offered then is not stored.
- R10: Address bits above log2(DEPTH) are ignored, so the read starts at the address modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| io_in | input | 2 | Sampled level of the two data lines |
| io_out | output | 2 | Value driven on the two data lines |
| io_oe | output | 2 | Per-line output enable |
| wr_valid | input | 1 | Preload write offered |
| wr_ready | output | 1 | Preload write can be taken |
| wr_addr | input | log2(DEPTH) | Preload byte address |
| wr_data | input | 8 | Preload byte |

## Verification
Two functions can fall in the same cycle. One is the byte boundary, where the pointer steps and may wrap. The other is the chip select release, which ends the stream. The bench provokes both by raising chip select in the middle of a byte and right at a wrap point, then running a fresh read. It judges the result by checking that the enable drops within four clocks and that the next read starts from its own address and not from the stale pointer. A cycle-level model in the bench also checks every clock that the lines are never enabled outside the window it predicts. This covers the dummy phase and rejected commands.

// File: rtl/dio_resp_pkg.sv
package dio_resp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_SKIP  = 3'd5
  } phase_e;

  localparam int BYTE_W     = 8;
  localparam int PAIRS_PER_B = BYTE_W / 2;
endpackage

// File: rtl/dio_resp_sync.sv
// Two-stage synchroniser bank for the asynchronous serial pins.
module dio_resp_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= rst_val;
      stage2_q <= rst_val;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/dio_resp_store.sv
// Byte storage: one write port from the preload interface, one combinational read.
module dio_resp_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells_q[waddr] <= wdata;
  end

  assign rdata = cells_q[raddr];
endmodule

// File: rtl/dio_resp_engine.sv
// Phase sequencer: command, address, dummy, then the output stream.
module dio_resp_engine
  import dio_resp_pkg::*;
#(
  parameter int          DEPTH      = 256,
  parameter logic [7:0]  READ_CODE  = 8'hBB,
  parameter int          ADDR_BITS  = 24,
  parameter int          DUMMY_CLKS = 4,
  localparam int AW        = $clog2(DEPTH),
  localparam int ADDR_CLKS = ADDR_BITS / 2,
  localparam int CW        = $clog2(ADDR_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          cs_n_s,
  input  logic [1:0]    io_s,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] rd_ptr,
  output logic [1:0]    line_out,
  output logic          line_oe,
  output logic          idle
);
  phase_e        phase_q;
  phase_e        eff_phase;
  logic          sck_prev_q;
  logic          sck_rise;
  logic          sck_fall;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cmd_q;
  logic [7:0]    cmd_next;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_next;
  logic [7:0]    shift_q;
  logic [1:0]    pair_q;
  logic          first_q;
  logic          oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_s;
  end

  assign sck_rise  = sck_s & ~sck_prev_q;
  assign sck_fall  = ~sck_s & sck_prev_q;
  assign eff_phase = (phase_q == PH_IDLE) ? PH_CMD : phase_q;
  assign cmd_next  = {cmd_q[6:0], io_s[0]};
  assign ptr_next  = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      ptr_q   <= '0;
      shift_q <= '0;
      pair_q  <= '0;
      first_q <= 1'b1;
      oe_q    <= 1'b0;
    end else if (cs_n_s) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pair_q  <= '0;
      first_q <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= eff_phase;
      unique case (eff_phase)
        PH_CMD: if (sck_rise) begin
          cmd_q <= cmd_next;
          if (cnt_q == CW'(7)) begin
            cnt_q   <= '0;
            phase_q <= (cmd_next == READ_CODE) ? PH_ADDR : PH_SKIP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ADDR: if (sck_rise) begin
          addr_q <= {addr_q[AW-3:0], io_s[1], io_s[0]};
          if (cnt_q == CW'(ADDR_CLKS - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_DUMMY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DUMMY: if (sck_rise) begin
          if (cnt_q == CW'(DUMMY_CLKS - 1)) begin
            cnt_q   <= '0;
            ptr_q   <= addr_q;
            phase_q <= PH_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: if (sck_fall) begin
          oe_q <= 1'b1;
          if (first_q || pair_q == 2'(PAIRS_PER_B - 1)) begin
            shift_q <= rd_byte;
            ptr_q   <= ptr_next;
            pair_q  <= '0;
            first_q <= 1'b0;
          end else begin
            shift_q <= {shift_q[5:0], 2'b00};
            pair_q  <= pair_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_ptr   = ptr_q;
  assign line_out = shift_q[7:6];
  assign line_oe  = oe_q;
  assign idle     = cs_n_s && (phase_q == PH_IDLE);
endmodule

// File: rtl/dio_read_responder.sv
module dio_read_responder #(
  parameter int         DEPTH     = 256,
  parameter logic [7:0] READ_CODE = 8'hBB,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic [1:0]    io_in,
  output logic [1:0]    io_out,
  output logic [1:0]    io_oe,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);
  logic [3:0]    pins_s;
  logic [7:0]    rd_byte;
  logic [AW-1:0] rd_ptr;
  logic          line_oe;
  logic          idle;

  dio_resp_sync #(.W(4)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (4'b0100),
    .d_async ({spi_sck, spi_cs_n, io_in}),
    .d_sync  (pins_s)
  );

  dio_resp_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_valid & wr_ready),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (rd_byte)
  );

  dio_resp_engine #(.DEPTH(DEPTH), .READ_CODE(READ_CODE)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (pins_s[3]),
    .cs_n_s   (pins_s[2]),
    .io_s     (pins_s[1:0]),
    .rd_byte  (rd_byte),
    .rd_ptr   (rd_ptr),
    .line_out (io_out),
    .line_oe  (line_oe),
    .idle     (idle)
  );

  assign io_oe    = {2{line_oe}};
  assign wr_ready = idle;
endmodule

// File: rtl/dio_read_responder_chk.sv
module dio_read_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic [1:0] io_out,
  input logic [1:0] io_oe,
  input logic       wr_ready
);
  logic [2:0] cyc_q, cs_hi_q, cs_lo_q, sck_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0; cs_hi_q <= '0; cs_lo_q <= '0; sck_hi_q <= '0;
    end else begin
      if (cyc_q != 3'd7) cyc_q <= cyc_q + 1'b1;
      cs_hi_q  <= !spi_cs_n ? '0 : (cs_hi_q == 3'd7 ? cs_hi_q : cs_hi_q + 1'b1);
      cs_lo_q  <= spi_cs_n  ? '0 : (cs_lo_q == 3'd7 ? cs_lo_q : cs_lo_q + 1'b1);
      sck_hi_q <= !spi_sck  ? '0 : (sck_hi_q == 3'd7 ? sck_hi_q : sck_hi_q + 1'b1);
    end
  end

  AST_RELEASE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_q >= 3'd4) |-> (io_oe == 2'b00)); // R7

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_q >= 3'd4) |-> !wr_ready); // R9

  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_hi_q >= 3'd5 && cs_lo_q >= 3'd5) |-> $stable(io_out)); // R5

  AST_OE_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd4 && $rose(io_oe[0])) |-> ($past(spi_cs_n, 3) == 1'b0)); // R4
endmodule

bind dio_read_responder dio_read_responder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .io_out   (io_out),
  .io_oe    (io_oe),
  .wr_ready (wr_ready)
);

// File: tb/dio_read_responder_bench.sv
module dio_read_responder_bench;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          spi_sck = 1'b0;
  logic          spi_cs_n = 1'b1;
  logic [1:0]    io_in = 2'b00;
  logic [1:0]    io_out;
  logic [1:0]    io_oe;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;

  int  n_run = 0;
  int  n_fail = 0;
  bit  drive_ok = 1'b0;
  bit  finished = 1'b0;
  logic [7:0] model_mem [DEPTH];

  always #2 clk = ~clk;

  dio_read_responder u_dio_read_responder (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock model: lines may only be enabled once the first data fall has been issued (R4, R8).
  always @(negedge clk) begin
    if (rst_n && !finished && !drive_ok)
      check(io_oe == 2'b00, "R4/R8 enable outside window", io_oe, 0);
  end

  task automatic bit_clk(input logic [1:0] din, input bit first_data, output logic [1:0] dout);
    spi_sck = 1'b0;
    io_in = din;
    if (first_data) drive_ok = 1'b1;
    repeat (4) @(negedge clk);
    dout = io_out;
    spi_sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_txn();
    spi_sck = 1'b0;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(io_oe == 2'b00, "R7 release after deselect", io_oe, 0);
    drive_ok = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic preload(input int a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model_mem[a] = d;
  endtask

  // Full transaction; stop_pairs > 0 aborts after that many data pairs.
  task automatic read_txn(input logic [7:0] cmd, input logic [23:0] a, input int nbytes,
                          input int stop_pairs, input string req);
    logic [1:0] got;
    logic [7:0] exp_b;
    logic [7:0] q[$];
    int pairs;
    pairs = 0;
    for (int i = 0; i < nbytes; i++) q.push_back(model_mem[(int'(a) + i) % DEPTH]);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) bit_clk({1'b1, cmd[i]}, 1'b0, got);
    for (int i = 11; i >= 0; i--) bit_clk({a[2*i+1], a[2*i]}, 1'b0, got);
    for (int i = 0; i < 4; i++) bit_clk(2'(i * 3 + 1), 1'b0, got);
    if (cmd != 8'hBB) begin
      for (int i = 0; i < 4 * nbytes; i++) bit_clk(2'(i), 1'b0, got);
      end_txn();
      return;
    end
    for (int b = 0; b < nbytes; b++) begin
      exp_b = q.pop_front();
      for (int p = 0; p < 4; p++) begin
        if (stop_pairs > 0 && pairs == stop_pairs) begin
          end_txn();
          return;
        end
        bit_clk(2'b00, (b == 0 && p == 0), got);
        check(io_oe == 2'b11, {req, " enable during data"}, io_oe, 3);
        check(got == exp_b[7-2*p -: 2], {req, " data pair"}, got, exp_b[7-2*p -: 2]);
        pairs++;
      end
    end
    end_txn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(io_oe == 2'b00, "R1 enable after reset", io_oe, 0);
    check(wr_ready == 1'b1, "R1 ready after reset", wr_ready, 1);
    // R9: preload through valid/ready
    for (int i = 0; i < DEPTH; i++) preload(i, 8'((i * 37 + 11) ^ (i >> 3)));
    // R2 R3 R5 R6: basic reads at several addresses
    read_txn(8'hBB, 24'h000000, 3, 0, "R2/R3/R5");
    read_txn(8'hBB, 24'h00005A, 5, 0, "R3/R6 increment");
    // R6: wraparound at DEPTH-1
    read_txn(8'hBB, 24'(DEPTH - 2), 4, 0, "R6 wrap");
    // R10: upper address bits ignored
    read_txn(8'hBB, 24'hA5C310, 2, 0, "R10 high bits");
    // R8: foreign commands, including a near miss, then a valid read
    read_txn(8'h3B, 24'h000010, 3, 0, "R8");
    read_txn(8'hBA, 24'h000020, 2, 0, "R8");
    read_txn(8'hBB, 24'h000033, 2, 0, "R8 recovery");
    // R7: abort mid-byte, abort at the wrap boundary, then fresh reads
    read_txn(8'hBB, 24'h000040, 2, 6, "R7 abort");
    read_txn(8'hBB, 24'h000081, 2, 0, "R7 fresh");
    read_txn(8'hBB, 24'(DEPTH - 1), 2, 4, "R7 abort at wrap");
    read_txn(8'hBB, 24'h000007, 2, 0, "R7 fresh after wrap");
    // R9: write offered while selected is not taken
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    check(wr_ready == 1'b0, "R9 ready while selected", wr_ready, 0);
    wr_valid = 1'b1; wr_addr = AW'(5); wr_data = ~model_mem[5];
    repeat (6) @(negedge clk);
    wr_valid = 1'b0;
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(wr_ready == 1'b1, "R9 ready after deselect", wr_ready, 1);
    read_txn(8'hBB, 24'h000005, 1, 0, "R9 blocked write");
    // R9: accepted write visible in next read
    preload(9, 8'hC6);
    read_txn(8'hBB, 24'h000009, 1, 0, "R9 accepted write");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule